// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address for a system with 4 KB pages. A request first goes to a small fully associative translation cache that holds recent virtual-page-to-frame mappings. On a hit the answer comes back without any memory traffic. On a miss the block walks a two-level page table in memory. It issues one 32-bit word read for the top-level entry and, if that entry is present, a second read for the leaf entry. It then returns either the translated address or a fault.

The top-level table base comes from a register input, `rootBase`, that software reloads on a context switch. Cached mappings carry no context tag, so the `flush` input must be pulsed when `rootBase` changes. The block takes one translation at a time and holds `reqReady` low until that translation has been answered. Memory reads are single-cycle request pulses. The matching data comes back on `memRespValid` one or more cycles later.

Entry format, used at both levels: bit 0 = valid, bit 1 = write allowed, bit 2 = dirty, and bits 31:12 = the 4 KB-aligned base of the next-level table or of the page frame. Bit 2 and bits 11:3 are carried in memory but ignored by the walker. For a top-level entry, bit 1 is ignored as well.

Top module: `pageWalker`

## Requirements
- R1: After reset, `reqReady` is 1 and `rspValid`, `memReqValid`, `rspPageFault` and `rspPermFault` are 0.
- R2: On a successful translation, `rspPaddr[11:0]` equals the request's `vaddr[11:0]` and `rspPaddr[31:12]` equals bits 31:12 of the leaf entry. Bits 11:2 of the leaf entry do not affect the result.
- R3: On a cache miss, the first memory read goes to `rootBase + vaddr[31:22]*4`. The second read, if issued, goes to `{topEntry[31:12], 12'h000} + vaddr[21:12]*4`.
- R4: A top-level entry with bit 0 clear ends the walk after exactly one read, with `rspPageFault` = 1.
- R5: A leaf entry with bit 0 clear gives `rspPageFault` = 1 after exactly two reads.
- R6: A write request (`reqWrite` = 1) to a valid leaf whose bit 1 is clear gives `rspPermFault` = 1. A read request to the same page succeeds. This holds for answers from the walk and for answers from the cache.
- R7: A request whose virtual page number is in the cache is answered with no memory read. `rspValid` rises on the clock edge after the edge that accepts the request.
- R8: A walk that reaches a valid leaf fills the cache, including when it ends in a permission fault. A walk that ends in a page fault leaves the cache unchanged, so repeating the request walks again.
- R9: The cache holds 8 mappings and replaces them in round-robin order. After a flush and nine distinct fills, only the first mapping filled is gone.
- R10: A one-cycle `flush` pulse invalidates every cached mapping. Without a flush, a mapping filled under one `rootBase` is still returned after `rootBase` changes.
- R11: `reqReady` is 0 from the accepting edge until `rspValid` has been driven. `rspValid` and `memReqValid` are single-cycle pulses.
- R12: A response carries at most one of `rspPageFault` and `rspPermFault`. When either is set, `rspPaddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqReady | output | 1 | High when a new request can be accepted |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | Request is a write access |
| rootBase | input | 32 | Physical base of the top-level table |
| flush | input | 1 | Invalidate all cached mappings |
| memReqValid | output | 1 | Memory word read request, one cycle |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRespValid | input | 1 | Read data valid |
| memRespData | input | 32 | Entry word returned by memory |
| rspValid | output | 1 | Translation result pulse |
| rspPaddr | output | 32 | Physical address, 0 on a fault |
| rspPageFault | output | 1 | Entry at either level not present |
| rspPermFault | output | 1 | Write to a page without write permission |

## Verification
The bench sweeps twelve top-level indices against a spread of leaf indices, including 0 and 1023, and tries both read and write accesses. It fills the memory with arithmetic patterns so that every mix of missing top entry, missing leaf and write-protected leaf appears. Each address is translated twice. A walker that cached faulting walks would show zero reads on the repeat, and one that skipped caching permission-faulted leaves would show two. Entry addresses are checked read by read, so a shift or index-field swap shows up even when the returned data happens to agree. Junk in the ignored low bits of entries catches an offset taken from the wrong word. Separate sequences check that a ninth fill evicts exactly the oldest mapping, and that a stale mapping survives a root change until a flush removes it.

// File: rtl/walkPkg.sv
package walkPkg;
  localparam int ADDR_W = 32;
  localparam int OFF_W = 12;
  localparam int IDX_W = 10;
  localparam int VPN_W = ADDR_W - OFF_W;
  localparam int PFN_W = ADDR_W - OFF_W;
  localparam int ENTRY_BYTES_LOG2 = 2;
  localparam int BIT_PRESENT = 0;
  localparam int BIT_WRITABLE = 1;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_WAIT_TOP, ST_WAIT_LEAF} walkState_t;
  typedef enum logic [1:0] {RES_OK, RES_PAGE, RES_PERM} resKind_t;

  typedef struct packed {
    logic capture;
    logic issue;
    logic issueLeaf;
    logic respLoad;
    resKind_t respKind;
    logic fromCache;
    logic fill;
  } walkStrobe_t;

  typedef struct packed {
    logic hit;
    logic hitWritable;
    logic isWrite;
    logic entryPresent;
    logic entryWritable;
  } walkStatus_t;
endpackage

// File: rtl/walkTlb.sv
module walkTlb
  import walkPkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [VPN_W-1:0] lookupVpn,
  output logic             hit,
  output logic [PFN_W-1:0] hitPfn,
  output logic             hitWritable,
  input  logic             flush,
  input  logic             fill,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PFN_W-1:0] fillPfn,
  input  logic             fillWritable
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] slotValid;
  logic [ENTRIES-1:0] slotWritable;
  logic [VPN_W-1:0]   slotVpn [ENTRIES];
  logic [PFN_W-1:0]   slotPfn [ENTRIES];
  logic [ENTRIES-1:0] slotMatch;
  logic [PTR_W-1:0]   victimPtr;

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign slotMatch[g] = slotValid[g] && (slotVpn[g] == lookupVpn);
  end

  always_comb begin
    hit = |slotMatch;
    hitPfn = '0;
    hitWritable = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (slotMatch[i]) begin
        hitPfn = hitPfn | slotPfn[i];
        hitWritable = hitWritable | slotWritable[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      victimPtr <= '0;
    end else if (flush) begin
      slotValid <= '0;
    end else if (fill) begin
      slotValid[victimPtr] <= 1'b1;
      victimPtr <= (victimPtr == LAST_SLOT) ? '0 : victimPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill && !flush) begin
      slotVpn[victimPtr] <= fillVpn;
      slotPfn[victimPtr] <= fillPfn;
      slotWritable[victimPtr] <= fillWritable;
    end
  end
endmodule

// File: rtl/walkDatapath.sv
module walkDatapath
  import walkPkg::*;
#(
  parameter int CACHE_ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  output walkStatus_t       status,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] rootBase,
  input  logic              flush,
  output logic              memReqValid,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic [ADDR_W-1:0] memRespData,
  output logic              rspValid,
  output logic [ADDR_W-1:0] rspPaddr,
  output logic              rspPageFault,
  output logic              rspPermFault
);
  localparam int PAD_W = ADDR_W - IDX_W - ENTRY_BYTES_LOG2;

  logic [ADDR_W-1:0] vaddrQ;
  logic              writeQ;
  logic [IDX_W-1:0]  topIdx;
  logic [IDX_W-1:0]  leafIdx;
  logic [ADDR_W-1:0] topAddr;
  logic [ADDR_W-1:0] leafAddr;
  logic [PFN_W-1:0]  respBase;
  logic              tlbHit;
  logic              tlbWritable;
  logic [PFN_W-1:0]  tlbPfn;

  assign topIdx   = vaddrQ[ADDR_W-1 -: IDX_W];
  assign leafIdx  = vaddrQ[OFF_W +: IDX_W];
  assign respBase = memRespData[ADDR_W-1:OFF_W];
  assign topAddr  = rootBase + {{PAD_W{1'b0}}, topIdx, {ENTRY_BYTES_LOG2{1'b0}}};
  assign leafAddr = {respBase, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, leafIdx, {ENTRY_BYTES_LOG2{1'b0}}};

  walkTlb #(.ENTRIES(CACHE_ENTRIES)) tlb (
    .clk          (clk),
    .rstN         (rstN),
    .lookupVpn    (vaddrQ[ADDR_W-1:OFF_W]),
    .hit          (tlbHit),
    .hitPfn       (tlbPfn),
    .hitWritable  (tlbWritable),
    .flush        (flush),
    .fill         (strobe.fill),
    .fillVpn      (vaddrQ[ADDR_W-1:OFF_W]),
    .fillPfn      (respBase),
    .fillWritable (memRespData[BIT_WRITABLE])
  );

  assign status.hit           = tlbHit;
  assign status.hitWritable   = tlbWritable;
  assign status.isWrite       = writeQ;
  assign status.entryPresent  = memRespData[BIT_PRESENT];
  assign status.entryWritable = memRespData[BIT_WRITABLE];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ       <= '0;
      writeQ       <= 1'b0;
      memReqValid  <= 1'b0;
      memReqAddr   <= '0;
      rspValid     <= 1'b0;
      rspPaddr     <= '0;
      rspPageFault <= 1'b0;
      rspPermFault <= 1'b0;
    end else begin
      memReqValid <= strobe.issue;
      rspValid    <= strobe.respLoad;
      if (strobe.capture) begin
        vaddrQ <= reqVaddr;
        writeQ <= reqWrite;
      end
      if (strobe.issue) begin
        memReqAddr <= strobe.issueLeaf ? leafAddr : topAddr;
      end
      if (strobe.respLoad) begin
        unique case (strobe.respKind)
          RES_OK: begin
            rspPaddr     <= {(strobe.fromCache ? tlbPfn : respBase), vaddrQ[OFF_W-1:0]};
            rspPageFault <= 1'b0;
            rspPermFault <= 1'b0;
          end
          RES_PERM: begin
            rspPaddr     <= '0;
            rspPageFault <= 1'b0;
            rspPermFault <= 1'b1;
          end
          default: begin
            rspPaddr     <= '0;
            rspPageFault <= 1'b1;
            rspPermFault <= 1'b0;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/walkCtrl.sv
module walkCtrl
  import walkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        memRespValid,
  input  walkStatus_t status,
  output walkStrobe_t strobe
);
  walkState_t state;
  walkState_t stateNext;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobe = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          stateNext = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.hit) begin
          strobe.respLoad = 1'b1;
          strobe.fromCache = 1'b1;
          strobe.respKind = (status.isWrite && !status.hitWritable) ? RES_PERM : RES_OK;
          stateNext = ST_IDLE;
        end else begin
          strobe.issue = 1'b1;
          stateNext = ST_WAIT_TOP;
        end
      end
      ST_WAIT_TOP: begin
        if (memRespValid) begin
          if (!status.entryPresent) begin
            strobe.respLoad = 1'b1;
            strobe.respKind = RES_PAGE;
            stateNext = ST_IDLE;
          end else begin
            strobe.issue = 1'b1;
            strobe.issueLeaf = 1'b1;
            stateNext = ST_WAIT_LEAF;
          end
        end
      end
      default: begin
        if (memRespValid) begin
          strobe.respLoad = 1'b1;
          stateNext = ST_IDLE;
          if (!status.entryPresent) begin
            strobe.respKind = RES_PAGE;
          end else begin
            strobe.fill = 1'b1;
            strobe.respKind = (status.isWrite && !status.entryWritable) ? RES_PERM : RES_OK;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNext;
  end
endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import walkPkg::*;
#(
  parameter int CACHE_ENTRIES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [31:0] reqVaddr,
  input  logic        reqWrite,
  input  logic [31:0] rootBase,
  input  logic        flush,
  output logic        memReqValid,
  output logic [31:0] memReqAddr,
  input  logic        memRespValid,
  input  logic [31:0] memRespData,
  output logic        rspValid,
  output logic [31:0] rspPaddr,
  output logic        rspPageFault,
  output logic        rspPermFault
);
  walkStrobe_t strobe;
  walkStatus_t status;

  walkCtrl ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .memRespValid (memRespValid),
    .status       (status),
    .strobe       (strobe)
  );

  walkDatapath #(.CACHE_ENTRIES(CACHE_ENTRIES)) dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .status       (status),
    .reqVaddr     (reqVaddr),
    .reqWrite     (reqWrite),
    .rootBase     (rootBase),
    .flush        (flush),
    .memReqValid  (memReqValid),
    .memReqAddr   (memReqAddr),
    .memRespData  (memRespData),
    .rspValid     (rspValid),
    .rspPaddr     (rspPaddr),
    .rspPageFault (rspPageFault),
    .rspPermFault (rspPermFault)
  );
endmodule

// File: rtl/walkChecker.sv
module walkChecker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqReady,
  input logic [31:0] reqVaddr,
  input logic        memReqValid,
  input logic        rspValid,
  input logic [31:0] rspPaddr,
  input logic        rspPageFault,
  input logic        rspPermFault
);
  logic [11:0] offsetQ;

  always_ff @(posedge clk) begin
    if (!rstN) offsetQ <= '0;
    else if (reqValid && reqReady) offsetQ <= reqVaddr[11:0];
  end

  // R11
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R11
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R11
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R11
  mem_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R12
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !(rspPageFault && rspPermFault));

  // R12
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && (rspPageFault || rspPermFault)) |-> (rspPaddr == 32'h0));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspPageFault && !rspPermFault) |-> (rspPaddr[11:0] == offsetQ));
endmodule

bind pageWalker walkChecker chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqVaddr     (reqVaddr),
  .memReqValid  (memReqValid),
  .rspValid     (rspValid),
  .rspPaddr     (rspPaddr),
  .rspPageFault (rspPageFault),
  .rspPermFault (rspPermFault)
);

// File: tb/pageWalker_test.sv
module pageWalker_test;
  localparam logic [31:0] ROOT_A = 32'h0010_0000;
  localparam logic [31:0] ROOT_B = 32'h0010_1000;
  localparam logic [31:0] TBL_A  = 32'h0020_0000;
  localparam logic [31:0] TBL_B  = 32'h00A0_0000;
  localparam logic [31:0] TBL_SPAN = 32'h0040_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqVaddr = '0;
  logic reqWrite = 1'b0;
  logic [31:0] rootBase = ROOT_A;
  logic flush = 1'b0;
  logic memReqValid;
  logic [31:0] memReqAddr;
  logic memRespValid = 1'b0;
  logic [31:0] memRespData = '0;
  logic rspValid;
  logic [31:0] rspPaddr;
  logic rspPageFault;
  logic rspPermFault;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int readCount = 0;
  logic [31:0] addrLog [0:4095];

  pageWalker uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .reqWrite(reqWrite), .rootBase(rootBase), .flush(flush),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr), .memRespValid(memRespValid),
    .memRespData(memRespData), .rspValid(rspValid), .rspPaddr(rspPaddr),
    .rspPageFault(rspPageFault), .rspPermFault(rspPermFault)
  );

  always #4 clk = ~clk;

  function automatic bit topPresent(input int sel, input int i1);
    return (sel == 0) ? (i1 % 3 != 2) : (i1 % 5 != 4);
  endfunction

  function automatic bit leafPresent(input int i1, input int i2);
    return ((i1 + i2) % 4) != 3;
  endfunction

  function automatic logic [19:0] leafPfn(input int sel, input int i1, input int i2);
    int v;
    v = (i1 * 37 + i2 * 5 + 1 + sel * 32'h5000) & 32'hFFFFF;
    return v[19:0];
  endfunction

  function automatic logic [31:0] memRead(input logic [31:0] a);
    logic [31:0] base;
    int i1;
    int i2;
    if (a[31:12] == ROOT_A[31:12] || a[31:12] == ROOT_B[31:12]) begin
      int sel = (a[31:12] == ROOT_B[31:12]) ? 1 : 0;
      i1 = int'(a[11:2]);
      base = ((sel == 1) ? TBL_B : TBL_A) + (32'(i1) << 12);
      return {base[31:12], 11'h5A4 >> 0, topPresent(sel, i1)};
    end
    if ((a >= TBL_A && a < TBL_A + TBL_SPAN) || (a >= TBL_B && a < TBL_B + TBL_SPAN)) begin
      int sel = (a >= TBL_B) ? 1 : 0;
      logic [31:0] off = a - ((sel == 1) ? TBL_B : TBL_A);
      i1 = int'(off >> 12);
      i2 = int'(a[11:2]);
      return {leafPfn(sel, i1, i2), 9'h0A5, 1'(i1 % 2), 1'(i2 % 2 == 0), leafPresent(i1, i2)};
    end
    return 32'h0;
  endfunction

  // Memory model: latency of 2 to 4 cycles after the request pulse
  bit pend = 1'b0;
  int pendCnt = 0;
  int latSeed = 0;
  logic [31:0] pendAddr = '0;
  always @(posedge clk) begin
    memRespValid <= 1'b0;
    if (memReqValid) begin
      pend <= 1'b1;
      pendAddr <= memReqAddr;
      pendCnt <= latSeed % 3;
      latSeed <= latSeed + 1;
      addrLog[readCount % 4096] <= memReqAddr;
      readCount <= readCount + 1;
    end else if (pend) begin
      if (pendCnt == 0) begin
        memRespValid <= 1'b1;
        memRespData <= memRead(pendAddr);
        pend <= 1'b0;
      end else begin
        pendCnt <= pendCnt - 1;
      end
    end
  end

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      report();
    end
  end

  task automatic checkEq(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic pulseFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic translate(input logic [31:0] va, input logic wr,
                           output logic [31:0] pa, output logic pf, output logic pm,
                           output int nReads, output int firstLog, output int lat,
                           output bit readyLow, output bit pulseOk);
    int start;
    @(negedge clk);
    reqVaddr = va;
    reqWrite = wr;
    reqValid = 1'b1;
    start = readCount;
    firstLog = start;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    readyLow = 1'b1;
    while (!rspValid && lat < 200) begin
      if (reqReady) readyLow = 1'b0;
      @(negedge clk);
      lat++;
    end
    pa = rspPaddr;
    pf = rspPageFault;
    pm = rspPermFault;
    nReads = readCount - start;
    @(negedge clk);
    pulseOk = !rspValid;
  endtask

  // Translate one address and check against the computed model.
  task automatic access(input int sel, input int dataSel, input logic [31:0] va,
                        input logic wr, input bit cached, input string readTag);
    int i1 = int'(va[31:22]);
    int i2 = int'(va[21:12]);
    bit lv1 = topPresent(sel, i1);
    bit lv2 = leafPresent(i1, i2);
    bit expPf;
    bit expPm;
    int expReads;
    logic [31:0] expPa;
    logic [31:0] pa;
    logic pf;
    logic pm;
    int nReads;
    int firstLog;
    int lat;
    bit readyLow;
    bit pulseOk;
    string tag;
    expPf = cached ? 1'b0 : (!lv1 || !lv2);
    expPm = !expPf && wr && (i2 % 2 != 0);
    expReads = cached ? 0 : (!lv1 ? 1 : 2);
    expPa = (expPf || expPm) ? 32'h0 : {leafPfn(dataSel, i1, i2), va[11:0]};
    tag = (!cached && !lv1) ? "R4" : ((!cached && !lv2) ? "R5" : (expPm ? "R6" : "R2"));
    translate(va, wr, pa, pf, pm, nReads, firstLog, lat, readyLow, pulseOk);
    checkEq(tag, "paddr", pa, expPa);
    checkEq("R12", "pageFault", 32'(pf), 32'(expPf));
    checkEq("R12", "permFault", 32'(pm), 32'(expPm));
    checkEq(readTag, "read count", 32'(nReads), 32'(expReads));
    checkEq("R11", "ready low during translation", 32'(readyLow), 32'd1);
    checkEq("R11", "single-cycle response", 32'(pulseOk), 32'd1);
    if (cached) checkEq("R7", "hit latency", 32'(lat), 32'd2);
    if (nReads >= 1 && expReads >= 1)
      checkEq("R3", "top entry address", addrLog[firstLog % 4096],
              ((sel == 1) ? ROOT_B : ROOT_A) + 32'(i1) * 4);
    if (nReads >= 2 && expReads >= 2)
      checkEq("R3", "leaf entry address", addrLog[(firstLog + 1) % 4096],
              ((sel == 1) ? TBL_B : TBL_A) + (32'(i1) << 12) + 32'(i2) * 4);
  endtask

  initial begin
    int leafSet [6] = '{0, 1, 2, 3, 5, 1023};
    int rrSet [9] = '{0, 1, 2, 4, 5, 6, 8, 9, 10};
    repeat (3) @(negedge clk);
    // R1: reset state
    checkEq("R1", "reqReady in reset", 32'(reqReady), 32'd1);
    checkEq("R1", "rspValid in reset", 32'(rspValid), 32'd0);
    checkEq("R1", "memReqValid in reset", 32'(memReqValid), 32'd0);
    checkEq("R1", "faults in reset", 32'({rspPageFault, rspPermFault}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "reqReady after reset", 32'(reqReady), 32'd1);

    // Sweep: every mix of missing top, missing leaf, write protection; R8 on repeats
    for (int i1 = 0; i1 < 12; i1++) begin
      for (int j = 0; j < 6; j++) begin
        int i2 = leafSet[j];
        logic [31:0] va = {10'(i1), 10'(i2), 12'((i1 * 291 + i2 * 17) & 12'hFFF)};
        logic w = 1'((i1 + j) % 2);
        bit filled = topPresent(0, i1) && leafPresent(i1, i2);
        pulseFlush();
        access(0, 0, va, w, 1'b0, "R3");
        access(0, 0, {va[31:12], ~va[11:0]}, ~w, filled, "R8");
      end
    end

    // R9: round-robin replacement after nine fills
    pulseFlush();
    for (int k = 0; k < 9; k++)
      access(0, 0, {10'd0, 10'(rrSet[k]), 12'h123}, 1'b0, 1'b0, "R9");
    for (int k = 1; k < 9; k++)
      access(0, 0, {10'd0, 10'(rrSet[k]), 12'h456}, 1'b0, 1'b1, "R9");
    access(0, 0, {10'd0, 10'(rrSet[0]), 12'h789}, 1'b0, 1'b0, "R9");

    // R10: mapping survives a root change until flushed
    pulseFlush();
    access(0, 0, {10'd1, 10'd4, 12'hABC}, 1'b0, 1'b0, "R10");
    @(negedge clk);
    rootBase = ROOT_B;
    access(1, 0, {10'd1, 10'd4, 12'hABD}, 1'b0, 1'b1, "R10");
    pulseFlush();
    access(1, 1, {10'd1, 10'd4, 12'hABE}, 1'b0, 1'b0, "R10");
    access(1, 1, {10'd1, 10'd4, 12'hABF}, 1'b1, 1'b1, "R10");

    repeat (4) @(negedge clk);
    report();
  end
endmodule